// File: doc/BRIEF.md
# Home-Node Coherence Directory Slice

This block is one tile's share of a distributed coherence directory. Each line of the tile's last-level cache carries its directory entry: a stable state and a bit-vector of the cores that hold the line. Because the directory lives inside the cache, one lookup gives both the cache hit and the coherence state. A line that is absent from the cache is therefore absent from every private cache on the chip.

Private-cache controllers send read-shared, read-exclusive and writeback requests. The slice first checks that the line's address really belongs to this tile. It then looks up the line and sends point-to-point messages on a single output port: data grants, invalidations, forwards to an owner, recalls and memory reads and writes. The slice handles one transaction at a time. It holds `req_ready` low until that transaction has finished, so requests to any line are serialised.

When a miss needs a frame that is already in use, the direct-mapped frame at that index is the victim. Every core holding the victim is recalled, and the slice waits until all recall acknowledgements have arrived. Only then is the victim written back (if dirty or owned) and the new line fetched.

Top module: `dir_home_slice`

## Requirements
- R1: A request whose tile field (address bits [OFF_W+CW-1:OFF_W]) differs from TILE_ID raises `err_misroute` for one cycle, one cycle after acceptance. No message is sent and no line changes.
- R2: `req_ready` stays low from the acceptance of a request that needs acknowledgements, owner data or memory until that request's final message. A request held during that time is not taken.
- R3: A read miss with no victim to evict sends a memory read for the line address (offset bits zero) one cycle after acceptance. After `mem_valid`, it sends a shared grant (read-shared) or an exclusive grant (read-exclusive) to the requester one cycle later.
- R4: A read-shared hit on a shared line sends a shared grant one cycle after acceptance and adds the requester to the sharer list.
- R5: A read-exclusive hit on a shared line sends an invalidation to each other listed sharer, one per cycle in ascending core order, and to no other core. The exclusive grant follows only after every one of those cores has acknowledged.
- R6: A read-shared request to a line owned by another core forwards to the owner. After the owner answers, the requester gets a shared grant, and both cores are then listed as sharers.
- R7: A read-exclusive request to a line owned by another core forwards to the owner. After the owner answers, the requester gets an exclusive grant and becomes the only holder. A request from the current owner gets an exclusive grant at once.
- R8: A writeback always receives a writeback acknowledgement. Only a writeback from the current owner changes the line: it leaves the line resident with no sharers and marked dirty.
- R9: A miss whose victim has sharers sends a recall to each sharer in ascending order and waits for all acknowledgements. It then sends a memory write of the victim if the victim was dirty or owned, and then the memory read.
- R10: Request codes are 0 read-shared, 1 read-exclusive, 2 writeback, 3 none; code 3 is accepted with no effect. Message codes are 0 shared grant, 1 exclusive grant, 2 invalidate, 3 forward-shared, 4 forward-exclusive, 5 writeback ack, 6 recall, 7 memory read, 8 memory write. Memory messages carry destination 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice can take a request this cycle |
| req_type | input | 2 | Request code (R10) |
| req_core | input | CW | Requesting core |
| req_addr | input | ADDR_W | Request address |
| ack_valid | input | 1 | A core acknowledges an invalidation or recall, or returns owner data |
| ack_core | input | CW | Core giving the acknowledgement |
| mem_valid | input | 1 | Fill from memory has arrived |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 4 | Message code (R10) |
| msg_dest | output | CW | Destination core |
| msg_addr | output | ADDR_W | Line address of the message |
| err_misroute | output | 1 | Request addressed to another home tile |

## Verification
A wrong sharer vector shows up at the ports as invalidations or recalls sent to the wrong cores, or in the wrong order. The error appears at the next read-exclusive or eviction that touches the line, which may come many transactions after the faulty update. A wrong stable state appears sooner, as the wrong kind of message: a grant where a forward was due, or a missing memory write for a dirty victim. It shows on the cycle after the next access to that line. Wrong acknowledgement counting or a wrong busy flag shows as a grant sent too early, or as a second request accepted while one is still open.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    RQ_GETS = 2'd0,
    RQ_GETX = 2'd1,
    RQ_PUTM = 2'd2,
    RQ_NONE = 2'd3
  } req_t;

  typedef enum logic [3:0] {
    MS_DATA_S   = 4'd0,
    MS_DATA_E   = 4'd1,
    MS_INV      = 4'd2,
    MS_FWD_GETS = 4'd3,
    MS_FWD_GETX = 4'd4,
    MS_WB_ACK   = 4'd5,
    MS_RECALL   = 4'd6,
    MS_MEM_RD   = 4'd7,
    MS_MEM_WR   = 4'd8
  } msg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SENDV,
    ST_WAITA,
    ST_WAITO,
    ST_MRD,
    ST_WAITM
  } fsm_t;
endpackage

// File: rtl/dir_home_check.sv
module dir_home_check #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int CW      = 2,
  parameter int IDX_W   = 2,
  parameter int TILE_ID = 0
) (
  input  logic [ADDR_W-1:0]              addr,
  output logic                           home,
  output logic [IDX_W-1:0]               idx,
  output logic [ADDR_W-OFF_W-CW-IDX_W-1:0] tag
);
  assign home = (addr[OFF_W +: CW] == CW'(TILE_ID));
  assign idx  = addr[OFF_W+CW +: IDX_W];
  assign tag  = addr[ADDR_W-1 : OFF_W+CW+IDX_W];
endmodule

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int W  = 4,
  parameter int CW = 2
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [CW-1:0] idx,
  output logic [W-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = CW'(i);
    end
    any    = |vec;
    onehot = any ? (W'(1) << idx) : '0;
  end
endmodule

// File: rtl/dir_line_store.sv
module dir_line_store #(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 8,
  parameter int NT    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_mst,
  output logic             rd_dirty,
  output logic [NT-1:0]    rd_sh,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_mst,
  input  logic             wr_dirty,
  input  logic [NT-1:0]    wr_sh
);
  logic             v_q [LINES];
  logic [TAG_W-1:0] t_q [LINES];
  logic             m_q [LINES];
  logic             d_q [LINES];
  logic [NT-1:0]    s_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[g] <= 1'b0;
        t_q[g] <= '0;
        m_q[g] <= 1'b0;
        d_q[g] <= 1'b0;
        s_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        v_q[g] <= wr_valid;
        t_q[g] <= wr_tag;
        m_q[g] <= wr_mst;
        d_q[g] <= wr_dirty;
        s_q[g] <= wr_sh;
      end
    end
  end

  assign rd_valid = v_q[rd_idx];
  assign rd_tag   = t_q[rd_idx];
  assign rd_mst   = m_q[rd_idx];
  assign rd_dirty = d_q[rd_idx];
  assign rd_sh    = s_q[rd_idx];
endmodule

// File: rtl/dir_home_slice.sv
module dir_home_slice
  import dir_pkg::*;
#(
  parameter int GRID    = 2,
  parameter int TILE_ID = 1,
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int LINES   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_type,
  input  logic [$clog2(GRID*GRID)-1:0]  req_core,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic                          ack_valid,
  input  logic [$clog2(GRID*GRID)-1:0]  ack_core,
  input  logic                          mem_valid,
  output logic                          msg_valid,
  output logic [3:0]                    msg_type,
  output logic [$clog2(GRID*GRID)-1:0]  msg_dest,
  output logic [ADDR_W-1:0]             msg_addr,
  output logic                          err_misroute
);
  localparam int NT    = GRID * GRID;
  localparam int CW    = $clog2(NT);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - CW - IDX_W;

  function automatic logic [NT-1:0] core_bit(input logic [CW-1:0] c);
    return NT'(1) << c;
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, CW'(TILE_ID), OFF_W'(0)};
  endfunction

  fsm_t              st_q, st_n;
  logic [ADDR_W-1:0] cur_addr;
  logic [CW-1:0]     cur_core;
  req_t              cur_type;
  logic [NT-1:0]     vec_q, vec_n, pend_q, pend_ld_val, ack_mask;
  logic              pend_ld;
  msg_t              vtype_q, vtype_n;
  logic              evict_q, evict_n, vdirty_q, vdirty_n;

  logic              req_home, cur_home;
  logic [IDX_W-1:0]  req_idx, cur_idx, rd_idx;
  logic [TAG_W-1:0]  req_tag, cur_tag;

  dir_home_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CW(CW), .IDX_W(IDX_W), .TILE_ID(TILE_ID))
    u_req_chk (.addr(req_addr), .home(req_home), .idx(req_idx), .tag(req_tag));
  dir_home_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CW(CW), .IDX_W(IDX_W), .TILE_ID(TILE_ID))
    u_cur_chk (.addr(cur_addr), .home(cur_home), .idx(cur_idx), .tag(cur_tag));

  logic             rd_valid, rd_mst, rd_dirty;
  logic [TAG_W-1:0] rd_tag;
  logic [NT-1:0]    rd_sh;
  logic             wr_en, wr_valid, wr_mst, wr_dirty;
  logic [TAG_W-1:0] wr_tag;
  logic [NT-1:0]    wr_sh;

  assign rd_idx = (st_q == ST_IDLE) ? req_idx : cur_idx;

  dir_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .NT(NT)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_mst(rd_mst), .rd_dirty(rd_dirty), .rd_sh(rd_sh),
    .wr_en(wr_en), .wr_idx(rd_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_mst(wr_mst), .wr_dirty(wr_dirty), .wr_sh(wr_sh));

  logic          own_any, vec_any;
  logic [CW-1:0] own_idx, vec_idx;
  logic [NT-1:0] own_oh, vec_oh;

  dir_pick #(.W(NT), .CW(CW)) u_own (.vec(rd_sh), .any(own_any), .idx(own_idx), .onehot(own_oh));
  dir_pick #(.W(NT), .CW(CW)) u_vec (.vec(vec_q), .any(vec_any), .idx(vec_idx), .onehot(vec_oh));

  // named internal events for the checker
  logic ev_accept, ev_err;
  logic m_v;
  msg_t m_t;
  logic [CW-1:0]     m_d;
  logic [ADDR_W-1:0] m_a;

  logic          hit;
  logic [NT-1:0] rbit, others;
  req_t          rq;

  assign req_ready = (st_q == ST_IDLE);
  assign ev_accept = req_valid && req_ready;
  assign rq        = req_t'(req_type);

  always_comb begin
    st_n = st_q;
    vec_n = vec_q;
    vtype_n = vtype_q;
    evict_n = evict_q;
    vdirty_n = vdirty_q;
    pend_ld = 1'b0;
    pend_ld_val = '0;
    wr_en = 1'b0;
    wr_valid = rd_valid;
    wr_tag = rd_tag;
    wr_mst = rd_mst;
    wr_dirty = rd_dirty;
    wr_sh = rd_sh;
    m_v = 1'b0;
    m_t = MS_DATA_S;
    m_d = cur_core;
    m_a = line_addr(cur_tag, cur_idx);
    ev_err = 1'b0;
    hit = 1'b0;
    rbit = core_bit(cur_core);
    others = '0;
    unique case (st_q)
      ST_IDLE: if (ev_accept) begin
        rbit = core_bit(req_core);
        hit = rd_valid && (rd_tag == req_tag);
        m_d = req_core;
        m_a = line_addr(req_tag, req_idx);
        others = rd_sh & ~rbit;
        if (!req_home) begin
          ev_err = 1'b1;
        end else if (rq == RQ_PUTM) begin
          m_v = 1'b1;
          m_t = MS_WB_ACK;
          if (hit && rd_mst && rd_sh == rbit) begin
            wr_en = 1'b1; wr_mst = 1'b0; wr_dirty = 1'b1; wr_sh = '0;
          end
        end else if (rq != RQ_NONE && hit) begin
          m_v = 1'b1;
          if (rd_mst && own_idx != req_core) begin
            m_t = (rq == RQ_GETS) ? MS_FWD_GETS : MS_FWD_GETX;
            m_d = own_idx;
            st_n = ST_WAITO;
          end else if (rd_mst) begin
            m_t = MS_DATA_E;
          end else if (rq == RQ_GETS) begin
            m_t = MS_DATA_S;
            wr_en = 1'b1; wr_sh = rd_sh | rbit;
          end else if (others == '0) begin
            m_t = MS_DATA_E;
            wr_en = 1'b1; wr_mst = 1'b1; wr_sh = rbit;
          end else begin
            m_v = 1'b0;
            vec_n = others; pend_ld = 1'b1; pend_ld_val = others;
            vtype_n = MS_INV; evict_n = 1'b0;
            st_n = ST_SENDV;
          end
        end else if (rq != RQ_NONE) begin
          vdirty_n = rd_valid && (rd_dirty || rd_mst);
          if (rd_valid && rd_sh != '0) begin
            vec_n = rd_sh; pend_ld = 1'b1; pend_ld_val = rd_sh;
            vtype_n = MS_RECALL; evict_n = 1'b1;
            st_n = ST_SENDV;
          end else if (vdirty_n) begin
            m_v = 1'b1; m_t = MS_MEM_WR; m_d = '0;
            m_a = line_addr(rd_tag, req_idx);
            st_n = ST_MRD;
          end else begin
            m_v = 1'b1; m_t = MS_MEM_RD; m_d = '0;
            st_n = ST_WAITM;
          end
        end
      end
      ST_SENDV: begin
        m_v = 1'b1; m_t = vtype_q; m_d = vec_idx;
        vec_n = vec_q & ~vec_oh;
        if (vec_n == '0) st_n = ST_WAITA;
      end
      ST_WAITA: if (pend_q == '0) begin
        if (!evict_q) begin
          m_v = 1'b1; m_t = MS_DATA_E;
          wr_en = 1'b1; wr_mst = 1'b1; wr_sh = rbit;
          st_n = ST_IDLE;
        end else if (vdirty_q) begin
          m_v = 1'b1; m_t = MS_MEM_WR; m_d = '0;
          m_a = line_addr(rd_tag, cur_idx);
          st_n = ST_MRD;
        end else begin
          m_v = 1'b1; m_t = MS_MEM_RD; m_d = '0;
          st_n = ST_WAITM;
        end
      end
      ST_MRD: begin
        m_v = 1'b1; m_t = MS_MEM_RD; m_d = '0;
        st_n = ST_WAITM;
      end
      ST_WAITM: if (mem_valid) begin
        m_v = 1'b1;
        m_t = (cur_type == RQ_GETX) ? MS_DATA_E : MS_DATA_S;
        wr_en = 1'b1; wr_valid = 1'b1; wr_tag = cur_tag; wr_dirty = 1'b0;
        wr_mst = (cur_type == RQ_GETX); wr_sh = rbit;
        st_n = ST_IDLE;
      end
      ST_WAITO: if (ack_valid && ack_core == own_idx) begin
        m_v = 1'b1; wr_en = 1'b1; wr_dirty = 1'b1;
        if (cur_type == RQ_GETS) begin
          m_t = MS_DATA_S; wr_mst = 1'b0; wr_sh = rd_sh | rbit;
        end else begin
          m_t = MS_DATA_E; wr_mst = 1'b1; wr_sh = rbit;
        end
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign ack_mask = ack_valid ? core_bit(ack_core) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      cur_addr <= '0;
      cur_core <= '0;
      cur_type <= RQ_NONE;
      vec_q <= '0;
      pend_q <= '0;
      vtype_q <= MS_INV;
      evict_q <= 1'b0;
      vdirty_q <= 1'b0;
      msg_valid <= 1'b0;
      msg_type <= '0;
      msg_dest <= '0;
      msg_addr <= '0;
      err_misroute <= 1'b0;
    end else begin
      st_q <= st_n;
      if (ev_accept) begin
        cur_addr <= req_addr;
        cur_core <= req_core;
        cur_type <= rq;
      end
      vec_q <= vec_n;
      pend_q <= pend_ld ? pend_ld_val : (pend_q & ~ack_mask);
      vtype_q <= vtype_n;
      evict_q <= evict_n;
      vdirty_q <= vdirty_n;
      msg_valid <= m_v;
      msg_type <= m_t;
      msg_dest <= m_d;
      msg_addr <= m_a;
      err_misroute <= ev_err;
    end
  end

  logic unused_ok;
  assign unused_ok = cur_home ^ own_any ^ vec_any ^ (|own_oh);
endmodule

// File: rtl/dir_home_slice_chk.sv
module dir_home_slice_chk #(
  parameter int NT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          msg_valid,
  input logic [3:0]    msg_type,
  input logic          err_misroute,
  input logic [NT-1:0] pend_q,
  input logic [NT-1:0] vec_q,
  input logic          rd_valid,
  input logic          rd_mst,
  input logic [NT-1:0] rd_sh
);
  // R1: a misrouted request never produces a message
  p_misroute_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_misroute |-> !msg_valid);

  // R2: once memory has been asked for, the slice stays closed to new requests
  p_busy_after_memrd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 4'd7) |-> !req_ready);

  // R5: an exclusive grant leaves no acknowledgement outstanding
  p_grant_no_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 4'd1) |-> (pend_q == '0));

  // R5: cores still to be sent to are always among those awaited
  p_send_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_q & ~pend_q) == '0));

  // R7: an owned line has exactly one holder
  p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_mst) |-> ($countones(rd_sh) == 1));

  // R9: memory is read only after every recall has been acknowledged
  p_memrd_after_recall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 4'd7) |-> (pend_q == '0));
endmodule

bind dir_home_slice dir_home_slice_chk #(.NT(NT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .msg_valid(msg_valid),
  .msg_type(msg_type), .err_misroute(err_misroute), .pend_q(pend_q), .vec_q(vec_q),
  .rd_valid(rd_valid), .rd_mst(rd_mst), .rd_sh(rd_sh));

// File: tb/dir_home_slice_test.sv
`timescale 1ns/1ps
module dir_home_slice_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_type = '0;
  logic [1:0]  req_core = '0;
  logic [15:0] req_addr = '0;
  logic        ack_valid = 1'b0;
  logic [1:0]  ack_core = '0;
  logic        mem_valid = 1'b0;
  logic        msg_valid;
  logic [3:0]  msg_type;
  logic [1:0]  msg_dest;
  logic [15:0] msg_addr;
  logic        err_misroute;

  always #4 clk = ~clk;

  dir_home_slice uut (.*);

  typedef struct { int t; int d; logic [15:0] a; string r; } exp_t;
  exp_t exq[$];
  int   ackq[$];
  int   memn = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   err_exp = 0;
  bit   done = 0;

  // behavioural model of the line table
  bit       mv[4];
  int       mtag[4];
  bit       mm[4], md[4];
  bit [3:0] ms[4];

  function automatic logic [15:0] mk(int tg, int ix, int tile = 1);
    return {8'(tg), 2'(ix), 2'(tile), 4'h0};
  endfunction

  task automatic push(int t, int d, logic [15:0] a, string r);
    exp_t e;
    e.t = t; e.d = d; e.a = a; e.r = r;
    exq.push_back(e);
  endtask

  task automatic check(bit ok, string r, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic model(int ty, int c, logic [15:0] a);
    int ix, tg, own;
    bit hit;
    logic [15:0] la;
    if (a[5:4] != 2'd1) begin err_exp = 1; return; end   // R1
    if (ty == 3) return;                                  // R10
    ix = a[7:6]; tg = a[15:8]; la = {a[15:4], 4'h0};
    hit = mv[ix] && mtag[ix] == tg;
    own = 0;
    for (int i = 0; i < 4; i++) if (ms[ix][i]) begin own = i; break; end
    if (ty == 2) begin                                    // R8
      if (hit && mm[ix] && ms[ix] == 4'(1 << c)) begin
        md[ix] = 1; mm[ix] = 0; ms[ix] = 0;
      end
      push(5, c, la, "R8");
      return;
    end
    if (hit) begin
      if (mm[ix] && own != c) begin                       // R6 / R7
        push(ty == 0 ? 3 : 4, own, la, ty == 0 ? "R6" : "R7");
        push(ty == 0 ? 0 : 1, c, la, ty == 0 ? "R6" : "R7");
        md[ix] = 1;
        if (ty == 0) begin mm[ix] = 0; ms[ix][c] = 1; end
        else ms[ix] = 4'(1 << c);
      end else if (mm[ix]) begin
        push(1, c, la, "R7");
      end else if (ty == 0) begin                         // R4
        ms[ix][c] = 1;
        push(0, c, la, "R4");
      end else begin                                      // R5
        for (int i = 0; i < 4; i++) if (ms[ix][i] && i != c) push(2, i, la, "R5");
        push(1, c, la, "R5");
        mm[ix] = 1; ms[ix] = 4'(1 << c);
      end
    end else begin                                        // R3 / R9
      if (mv[ix]) begin
        for (int i = 0; i < 4; i++) if (ms[ix][i]) push(6, i, la, "R9");
        if (md[ix] || mm[ix]) push(8, 0, mk(mtag[ix], ix), "R9");
      end
      push(7, 0, la, "R3");
      push(ty == 1 ? 1 : 0, c, la, "R3");
      mv[ix] = 1; mtag[ix] = tg; mm[ix] = (ty == 1); md[ix] = 0; ms[ix] = 4'(1 << c);
    end
  endtask

  task automatic do_req(int ty, int c, logic [15:0] a);
    @(negedge clk);
    req_valid = 1; req_type = 2'(ty); req_core = 2'(c); req_addr = a;
    while (!req_ready) @(negedge clk);
    model(ty, c, a);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  // monitor and responder, sampled away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (err_misroute || err_exp) begin
        check(err_misroute == err_exp, "R1 err_misroute", err_misroute, err_exp);
        err_exp = 0;
      end
      if (msg_valid) begin
        if (exq.size() == 0) begin
          check(0, "R10 unexpected message type", msg_type, -1);
        end else begin
          exp_t e;
          e = exq.pop_front();
          check(msg_type == 4'(e.t), {e.r, " type"}, msg_type, e.t);
          check(msg_dest == 2'(e.d), {e.r, " dest"}, msg_dest, e.d);
          check(msg_addr == e.a, {e.r, " addr"}, msg_addr, e.a);
        end
        if (msg_type inside {4'd2, 4'd3, 4'd4, 4'd6}) ackq.push_back(msg_dest);
        if (msg_type == 4'd7) memn++;
      end
    end
  end

  always @(negedge clk) begin
    ack_valid = 0;
    mem_valid = 0;
    if (ackq.size() > 0) begin ack_valid = 1; ack_core = 2'(ackq.pop_front()); end
    if (memn > 0) begin mem_valid = 1; memn--; end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R2 reset ready", req_ready, 1);
    check(msg_valid == 0, "R10 reset msg_valid", msg_valid, 0);
    check(err_misroute == 0, "R1 reset err", err_misroute, 0);

    do_req(0, 0, mk(1, 0, 2));   // R1 misrouted
    settle();
    do_req(0, 0, mk(1, 0));      // R3 miss, empty frame
    settle();
    do_req(0, 2, mk(1, 0));      // R4
    do_req(0, 3, mk(1, 0));      // R4
    settle();
    do_req(1, 2, mk(1, 0));      // R5 invalidate 0 and 3
    check(req_ready == 0, "R2 stall during invalidation", req_ready, 0);
    settle();
    do_req(0, 1, mk(1, 0));      // R6 forward to owner 2
    settle();
    do_req(1, 0, mk(1, 0));      // R6 both 1 and 2 now invalidated
    settle();
    do_req(1, 3, mk(1, 0));      // R7 forward-exclusive to owner 0
    settle();
    do_req(0, 3, mk(1, 0));      // R7 owner re-request
    do_req(2, 1, mk(1, 0));      // R8 stale writeback
    do_req(2, 3, mk(1, 0));      // R8 owner writeback
    settle();
    do_req(0, 0, mk(2, 0));      // R9 dirty victim without sharers
    settle();
    do_req(1, 1, mk(2, 0));      // R5
    settle();
    do_req(0, 2, mk(3, 0));      // R9 recall owned victim
    check(req_ready == 0, "R2 stall during recall", req_ready, 0);
    settle();
    do_req(1, 3, mk(4, 1));      // R3 exclusive fill
    settle();
    do_req(3, 0, mk(4, 1));      // R10 no-op code
    do_req(2, 0, mk(9, 2));      // R8 writeback miss
    settle();
    check(exq.size() == 0, "R10 outstanding expected messages", exq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule